// File: doc/BRIEF.md
# Six-Read Address Command Detector

This block sits beside an asynchronous SRAM-style port and watches its address bus for a special run of six read accesses. Each read in such a run is served as a normal data read. The first five addresses form a fixed prefix. The sixth address picks one of four nonvolatile operations: store, recall, turn automatic store off, or turn automatic store on. When a run completes, the block raises a one-cycle command pulse that carries a 2-bit code. A store or recall run also raises a pulse that tells the data path to float its outputs.

The chip-side strobes (chip enable, output enable, write enable, all active low) must already be synchronous to `clk`. A read is counted once, in the cycle in which both chip enable and output enable become low while write enable is high. Either strobe may be the one that falls last. Only the lower 16 address bits are compared.

A run is discarded when a read does not match the expected address or when a write occurs. In that case the block raises an abort pulse. While the store/recall controller is busy, or while power is not good, detection is held off and the progress is cleared.

Top module: `seqcmd_detect`

## Requirements
- R1: After reset, `cmd_valid`, `cmd_float` and `seq_abort` are 0, and no partial run is held.
- R2: The prefix is five reads, in this order, with no other access between them: 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F.
- R3: A sixth read completes the run with `cmd_code`: 0x8FC0 gives 0 (store), 0x4C63 gives 1 (recall), 0x8B45 gives 2 (automatic store off), 0x4B46 gives 3 (automatic store on).
- R4: Address bit 16 is ignored. Only bits 15:0 are compared.
- R5: A read is counted when chip enable and output enable both become low while write enable is high. Either strobe may fall last. A read that is held low counts only once.
- R6: A write (chip enable and write enable low) discards any partial run. If a run was in progress, `seq_abort` pulses for one cycle.
- R7: A read that does not match discards the partial run. If a run was in progress, `seq_abort` pulses. If the address is 0x4E38, it starts a new run as step one.
- R8: While `busy` is high or `pwr_good` is low, no read is counted, no pulse is raised and the partial run is cleared.
- R9: `cmd_valid` is a single-cycle pulse, raised exactly once per completed run, in the cycle after the sixth read is counted.
- R10: `cmd_float` pulses together with `cmd_valid` only for store and recall, that is, for codes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low, synchronous |
| oe_n | input | 1 | Output enable, active low, synchronous |
| we_n | input | 1 | Write enable, active low, synchronous |
| addr | input | 17 | Address bus |
| busy | input | 1 | Store/recall controller busy |
| pwr_good | input | 1 | Supply is above its threshold |
| cmd_valid | output | 1 | Command pulse |
| cmd_code | output | 2 | Command code, valid while `cmd_valid` is high |
| cmd_float | output | 1 | Float the data outputs (store or recall) |
| seq_abort | output | 1 | A partial run was discarded |

## Verification
Directed runs complete all four commands, with reads paced by chip enable and by output enable. This separates the code mapping from the handling of the strobes. Further cases separate faults in the restart rule from faults in the abort logic:
- a run with an extra 0x4E38 inside it;
- a run broken by a write;
- a run broken by a mismatching sixth read;
- a run with bit 16 set;
- a run cut by `busy` or by a power drop.

Random reads biased toward the next expected address, mixed with writes and suppression pulses, reach deep partial runs from many different histories. Each pulse is compared with a bench model of the ordered match.

// File: rtl/seqcmd_detect.sv
module seqcmd_detect #(
  parameter int ADDR_W = 17,
  parameter int CMP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  input  logic              pwr_good,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  output logic              cmd_float,
  output logic              seq_abort
);
  localparam int LAST = 5;

  localparam logic [CMP_W-1:0] K_STORE  = CMP_W'(16'h8FC0);
  localparam logic [CMP_W-1:0] K_RECALL = CMP_W'(16'h4C63);
  localparam logic [CMP_W-1:0] K_AS_OFF = CMP_W'(16'h8B45);
  localparam logic [CMP_W-1:0] K_AS_ON  = CMP_W'(16'h4B46);

  function automatic logic [CMP_W-1:0] prefix(input logic [2:0] i);
    case (i)
      3'd0:    prefix = CMP_W'(16'h4E38);
      3'd1:    prefix = CMP_W'(16'hB1C7);
      3'd2:    prefix = CMP_W'(16'h83E0);
      3'd3:    prefix = CMP_W'(16'h7C1F);
      default: prefix = CMP_W'(16'h703F);
    endcase
  endfunction

  logic [2:0]       step;
  logic             rd_q, wr_q;
  logic [CMP_W-1:0] a;
  logic             hold, rd_act, wr_act, rd_evt, wr_evt;
  logic             is_cmd;
  logic [1:0]       code_n;

  assign a      = addr[CMP_W-1:0];
  assign hold   = busy | ~pwr_good;
  assign rd_act = ~ce_n & ~oe_n & we_n;
  assign wr_act = ~ce_n & ~we_n;
  assign rd_evt = rd_act & ~rd_q & ~hold;
  assign wr_evt = wr_act & ~wr_q & ~hold;

  always_comb begin
    is_cmd = 1'b1;
    code_n = 2'd0;
    case (a)
      K_STORE:  code_n = 2'd0;
      K_RECALL: code_n = 2'd1;
      K_AS_OFF: code_n = 2'd2;
      K_AS_ON:  code_n = 2'd3;
      default:  is_cmd = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      step      <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_float <= 1'b0;
      seq_abort <= 1'b0;
    end else begin
      rd_q      <= rd_act;
      wr_q      <= wr_act;
      cmd_valid <= 1'b0;
      cmd_float <= 1'b0;
      seq_abort <= 1'b0;
      if (hold) begin
        step <= '0;
      end else if (wr_evt) begin
        step      <= '0;
        seq_abort <= (step != 3'd0);
      end else if (rd_evt) begin
        if (step == 3'(LAST) && is_cmd) begin
          step      <= '0;
          cmd_valid <= 1'b1;
          cmd_code  <= code_n;
          cmd_float <= ~code_n[1];
        end else if (step != 3'(LAST) && a == prefix(step)) begin
          step <= step + 3'd1;
        end else begin
          step      <= (a == prefix(3'd0)) ? 3'd1 : 3'd0;
          seq_abort <= (step != 3'd0);
        end
      end
    end
  end

  p_step_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step <= 3'(LAST));
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_valid_needs_full_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(step) == 3'(LAST));
  p_no_abort_with_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && seq_abort));
  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!cmd_valid && !seq_abort && step == 3'd0));
  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (step == 3'd0 && !cmd_valid));
  p_float_store_recall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_float |-> (cmd_valid && !cmd_code[1]));
endmodule

// File: tb/test_seqcmd_detect.sv
module test_seqcmd_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [16:0] addr = '0;
  logic busy = 1'b0, pwr_good = 1'b1;
  logic cmd_valid, cmd_float, seq_abort;
  logic [1:0] cmd_code;

  int n_chk = 0, n_bad = 0;
  int m_step = 0;

  always #4 clk = ~clk;

  seqcmd_detect i_seqcmd_detect (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .busy(busy), .pwr_good(pwr_good),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_float(cmd_float), .seq_abort(seq_abort));

  function automatic logic [15:0] pre(input int i);
    case (i)
      0: pre = 16'h4E38;
      1: pre = 16'hB1C7;
      2: pre = 16'h83E0;
      3: pre = 16'h7C1F;
      default: pre = 16'h703F;
    endcase
  endfunction

  function automatic logic [15:0] cmdaddr(input int c);
    case (c)
      0: cmdaddr = 16'h8FC0;
      1: cmdaddr = 16'h4C63;
      2: cmdaddr = 16'h8B45;
      default: cmdaddr = 16'h4B46;
    endcase
  endfunction

  function automatic int cmd_of(input logic [15:0] a);
    cmd_of = -1;
    for (int c = 0; c < 4; c++) if (cmdaddr(c) == a) cmd_of = c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input bit v, input int code, input bit ab);
    chk(req, {31'd0, cmd_valid}, {31'd0, v});
    chk(req, {31'd0, seq_abort}, {31'd0, ab});
    chk({req, " R10"}, {31'd0, cmd_float}, {31'd0, v && code < 2});
    if (v) chk({req, " R3"}, {30'd0, cmd_code}, code);
  endtask

  task automatic rd(input logic [16:0] a, input bit via_oe, input string req);
    bit ev; int ec; bit ea;
    logic [15:0] lo;
    lo = a[15:0];
    ev = 0; ec = 0; ea = 0;
    if (m_step == 5 && cmd_of(lo) >= 0) begin
      ev = 1; ec = cmd_of(lo); m_step = 0;
    end else if (m_step < 5 && lo == pre(m_step)) begin
      m_step++;
    end else begin
      ea = (m_step != 0);
      m_step = (lo == 16'h4E38) ? 1 : 0;
    end
    @(negedge clk);
    addr = a; we_n = 1'b1;
    if (via_oe) ce_n = 1'b0; else oe_n = 1'b0;
    @(negedge clk);
    if (via_oe) oe_n = 1'b0; else ce_n = 1'b0;
    @(negedge clk);
    expect_out(req, ev, ec, ea);
    @(negedge clk);
    expect_out({req, " R5 held"}, 0, 0, 0);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [16:0] a);
    bit ea;
    ea = (m_step != 0);
    m_step = 0;
    @(negedge clk);
    addr = a; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    expect_out("R6", 0, 0, ea);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic hold_pulse(input bit use_busy);
    @(negedge clk);
    if (use_busy) busy = 1'b1; else pwr_good = 1'b0;
    addr = {1'b0, pre(m_step)}; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    expect_out("R8", 0, 0, 0);
    ce_n = 1'b1; oe_n = 1'b1; busy = 1'b0; pwr_good = 1'b1;
    m_step = 0;
    @(negedge clk);
  endtask

  task automatic run(input int c, input bit via_oe, input bit hi);
    for (int i = 0; i < 5; i++) rd({hi, pre(i)}, via_oe, "R2");
    rd({hi, cmdaddr(c)}, via_oe, "R9");
  endtask

  initial begin
    int seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    expect_out("R1", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1", 0, 0, 0);

    for (int c = 0; c < 4; c++) run(c, c[0], 1'b0);
    run(1, 1'b0, 1'b1);
    rd(17'h1_4E38, 1'b1, "R4");
    rd(17'h0_B1C7, 1'b0, "R4");
    rd(17'h1_83E0, 1'b1, "R4");
    rd(17'h0_7C1F, 1'b0, "R4");
    rd(17'h1_703F, 1'b0, "R4");
    rd(17'h1_8B45, 1'b1, "R4 R3");

    rd(17'h04E38, 0, "R2");
    rd(17'h0B1C7, 0, "R2");
    rd(17'h04E38, 0, "R7 restart");
    rd(17'h0B1C7, 0, "R7");
    rd(17'h083E0, 0, "R7");
    rd(17'h07C1F, 0, "R7");
    rd(17'h0703F, 0, "R7");
    rd(17'h08FC0, 0, "R7 complete");

    rd(17'h04E38, 1, "R6");
    rd(17'h0B1C7, 1, "R6");
    wr(17'h083E0);
    rd(17'h083E0, 1, "R6 after write");
    wr(17'h00000);

    for (int i = 0; i < 5; i++) rd({1'b0, pre(i)}, 0, "R7");
    rd(17'h01234, 0, "R7 bad sixth");
    rd(17'h08FC0, 0, "R7 no cmd");

    for (int i = 0; i < 5; i++) rd({1'b0, pre(i)}, 0, "R8");
    hold_pulse(1'b1);
    rd(17'h08FC0, 0, "R8 cleared");
    for (int i = 0; i < 3; i++) rd({1'b0, pre(i)}, 1, "R8");
    hold_pulse(1'b0);
    run(3, 1'b1, 1'b0);

    for (int it = 0; it < 600; it++) begin
      int r;
      logic [15:0] a;
      r = $urandom_range(0, 99);
      if (r < 8) wr({1'b0, 16'($urandom)});
      else if (r < 11) hold_pulse(r[0]);
      else begin
        int s;
        s = $urandom_range(0, 9);
        if (s < 7) a = (m_step == 5) ? cmdaddr($urandom_range(0, 3)) : pre(m_step);
        else if (s < 8) a = pre($urandom_range(0, 4));
        else if (s < 9) a = cmdaddr($urandom_range(0, 3));
        else a = 16'($urandom);
        rd({1'($urandom), a}, 1'($urandom), "R7 random");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule